// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Mixed Page Sizes

This block is a small, fully associative cache of virtual-to-physical page translations. Each cycle a requester may present a virtual address, an access kind (read or write) and the identifier of the running process. One cycle later the block reports one of three outcomes: a hit with the translated physical address, a miss, or a protection fault. Every slot is tagged with a process identifier and carries its own page size: 4 KB, 2 MB or 1 GB. The number of untranslated low address bits therefore changes from slot to slot.

Translations are installed by software through a refill port. The block does not walk page tables. A purge port removes either one translation, chosen by virtual page and process identifier, or every translation at once. This lets system software drop stale mappings after it changes permissions or takes part in a cross-core invalidation.

If an installed translation already covers the same page, the refill overwrites it in place. Otherwise the refill takes the lowest-numbered free slot. When no slot is free, a rotating pointer picks the slot to replace.

Top module: `tagged_tlb`

## Requirements
- R1: After reset no slot holds a translation, `rs_valid` is low, and the first lookup reports a miss.
- R2: A lookup presented in cycle N produces exactly one result in cycle N+1, with `rs_valid` high. With no lookup, `rs_valid` stays low the next cycle.
- R3: On a hit in a 4 KB slot, `rs_paddr` takes bits 31:12 from the stored frame and bits 11:0 from the virtual address.
- R4: A 2 MB slot compares only virtual bits 31:21 and passes bits 20:0 through. A 1 GB slot compares only bits 31:30 and passes bits 29:0 through. Size codes: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB.
- R5: A lookup whose process identifier differs from the slot's stored identifier misses.
- R6: A write that matches a slot installed with `fill_writable` = 0 reports a fault, with `rs_hit` low and `rs_paddr` zero. A read of the same slot hits.
- R7: A refill that matches no existing slot writes the lowest-numbered invalid slot, and the other slots stay intact.
- R8: When all slots are valid, a new refill replaces the slot under a rotating pointer. The pointer starts at 0 after reset and advances by one (wrapping) only on such replacements.
- R9: A refill with the same page size, the same virtual page and the same process identifier as a valid slot overwrites that slot. No other slot is disturbed and the pointer does not move.
- R10: A targeted purge invalidates only slots whose process identifier and virtual page (under the slot's own size) match. A purge naming another process has no effect.
- R11: A purge with `purge_all` high invalidates every slot in one cycle.
- R12: A lookup sees the table as it was before any refill or purge presented in the same cycle.
- R13: While `rs_valid` is high, exactly one of `rs_hit`, `rs_miss` and `rs_fault` is high. While it is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_pid | input | 8 | Current process identifier |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation found and permitted |
| rs_miss | output | 1 | No matching slot |
| rs_fault | output | 1 | Write to a read-only slot |
| rs_paddr | output | 32 | Physical address on hit, else zero |
| fill_valid | input | 1 | Refill request |
| fill_vaddr | input | 32 | Refill virtual address |
| fill_paddr | input | 32 | Refill physical frame address |
| fill_size | input | 2 | Refill page size code |
| fill_pid | input | 8 | Refill process identifier |
| fill_writable | input | 1 | Refill permits writes |
| purge_valid | input | 1 | Purge request |
| purge_all | input | 1 | Purge every slot |
| purge_vaddr | input | 32 | Targeted purge virtual address |
| purge_pid | input | 8 | Targeted purge process identifier |

## Verification
The assertions assume the input side is well formed. `fill_size` never carries code 3. Refills never install two overlapping pages of different sizes for one process, so at most one slot can match any lookup. `purge_all` is only meaningful while `purge_valid` is high.

The stimulus keeps within these limits. It uses only the three legal size codes and places all pages at non-overlapping addresses. It asserts `purge_all` only together with `purge_valid`. It applies refill and purge in the same cycle as a lookup only where R12 is being exercised.

// File: rtl/tlb_pkg.sv
// tlb_pkg: shared widths and the page-size encoding of the translation cache.
// Assumes: size code 3 is never loaded; it is treated as the smallest page.
package tlb_pkg;
    localparam int VA_WIDTH  = 32;
    localparam int PA_WIDTH  = 32;
    localparam int PID_WIDTH = 8;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    // Number of untranslated low address bits for a page size.
    function automatic int unsigned pg_offset_bits(pg_size_e sz);
        case (sz)
            PG_2M:   return 21;
            PG_1G:   return 30;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/tlb_match.sv
// tlb_match: compares one stored slot against a probe address and process id.
// The slot's page size decides how many low bits are ignored. Also emits
// the keep masks (upper bits that are translated) for address formation.
// Assumes: the offset width is below both address widths.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int VA_W  = VA_WIDTH,
    parameter int PA_W  = PA_WIDTH,
    parameter int PID_W = PID_WIDTH
) (
    input  logic             slot_vld,
    input  logic [VA_W-1:0]  slot_va,
    input  pg_size_e         slot_sz,
    input  logic [PID_W-1:0] slot_pid,
    input  logic [VA_W-1:0]  probe_va,
    input  logic [PID_W-1:0] probe_pid,
    output logic             match,
    output logic [VA_W-1:0]  va_keep,
    output logic [PA_W-1:0]  pa_keep
);
    // Build the masks and the compare for this slot's page size.
    always_comb begin
        va_keep = {VA_W{1'b1}} << pg_offset_bits(slot_sz);
        pa_keep = {PA_W{1'b1}} << pg_offset_bits(slot_sz);
        match   = slot_vld && (slot_pid == probe_pid)
                  && (((slot_va ^ probe_va) & va_keep) == '0);
    end
endmodule

// File: rtl/tlb_victim.sv
// tlb_victim: picks the slot a refill writes. An in-place duplicate wins,
// then the lowest invalid slot, then the rotating pointer.
// Assumes: at most one duplicate bit is set.
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     dup,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] idx,
    output logic             use_ptr
);
    // Priority search: duplicate, then first free, else pointer.
    always_comb begin
        logic found_dup;
        logic found_free;
        logic [IDX_W-1:0] dup_idx;
        logic [IDX_W-1:0] free_idx;
        found_dup  = 1'b0;
        found_free = 1'b0;
        dup_idx    = '0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dup[i]) begin
                found_dup = 1'b1;
                dup_idx   = IDX_W'(i);
            end
            if (!vld[i]) begin
                found_free = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        use_ptr = !found_dup && !found_free;
        if (found_dup)       idx = dup_idx;
        else if (found_free) idx = free_idx;
        else                 idx = ptr;
    end
endmodule

// File: rtl/tagged_tlb.sv
// tagged_tlb: fully associative, process-tagged translation cache with
// per-slot page size. Lookup results are registered (one cycle). Refill and
// purge update the table at the same edge, after that cycle's lookup.
// When both hit one slot in a cycle, the refill wins.
// Assumes: software never installs overlapping pages for one process;
// if it does, the lowest-numbered matching slot answers.
module tagged_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = VA_WIDTH,
    parameter int PA_W    = PA_WIDTH,
    parameter int PID_W   = PID_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic [PID_W-1:0] lk_pid,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic             rs_miss,
    output logic             rs_fault,
    output logic [PA_W-1:0]  rs_paddr,
    input  logic             fill_valid,
    input  logic [VA_W-1:0]  fill_vaddr,
    input  logic [PA_W-1:0]  fill_paddr,
    input  logic [1:0]       fill_size,
    input  logic [PID_W-1:0] fill_pid,
    input  logic             fill_writable,
    input  logic             purge_valid,
    input  logic             purge_all,
    input  logic [VA_W-1:0]  purge_vaddr,
    input  logic [PID_W-1:0] purge_pid
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [VA_W-1:0]    va_q  [ENTRIES];
    logic [PA_W-1:0]    pa_q  [ENTRIES];
    pg_size_e           sz_q  [ENTRIES];
    logic [PID_W-1:0]   pid_q [ENTRIES];
    logic [ENTRIES-1:0] wr_q;
    logic [IDX_W-1:0]   ptr_q;

    logic [ENTRIES-1:0] lk_hit, pg_hit, fl_hit, fl_dup;
    logic [VA_W-1:0]    lk_vkeep [ENTRIES];
    logic [PA_W-1:0]    lk_pkeep [ENTRIES];

    // One compare unit per slot for each of the three probe ports.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [VA_W-1:0] unused_v0, unused_v1;
        logic [PA_W-1:0] unused_p0, unused_p1;
        tlb_match #(.VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W)) u_lk (
            .slot_vld(vld_q[g]), .slot_va(va_q[g]), .slot_sz(sz_q[g]),
            .slot_pid(pid_q[g]), .probe_va(lk_vaddr), .probe_pid(lk_pid),
            .match(lk_hit[g]), .va_keep(lk_vkeep[g]), .pa_keep(lk_pkeep[g]));
        tlb_match #(.VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W)) u_pg (
            .slot_vld(vld_q[g]), .slot_va(va_q[g]), .slot_sz(sz_q[g]),
            .slot_pid(pid_q[g]), .probe_va(purge_vaddr), .probe_pid(purge_pid),
            .match(pg_hit[g]), .va_keep(unused_v0), .pa_keep(unused_p0));
        tlb_match #(.VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W)) u_fl (
            .slot_vld(vld_q[g]), .slot_va(va_q[g]), .slot_sz(sz_q[g]),
            .slot_pid(pid_q[g]), .probe_va(fill_vaddr), .probe_pid(fill_pid),
            .match(fl_hit[g]), .va_keep(unused_v1), .pa_keep(unused_p1));
        assign fl_dup[g] = fl_hit[g] && (sz_q[g] == pg_size_e'(fill_size));
    end

    logic [IDX_W-1:0] vic_idx;
    logic             vic_use_ptr;

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_vic (
        .vld(vld_q), .dup(fl_dup), .ptr(ptr_q),
        .idx(vic_idx), .use_ptr(vic_use_ptr));

    logic            sel_found, sel_wr;
    logic [PA_W-1:0] sel_pa;

    // Lowest-index matching slot forms the translated address.
    always_comb begin
        sel_found = 1'b0;
        sel_wr    = 1'b0;
        sel_pa    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_hit[i]) begin
                sel_found = 1'b1;
                sel_wr    = wr_q[i];
                sel_pa    = (pa_q[i] & lk_pkeep[i])
                          | (PA_W'(lk_vaddr) & ~lk_pkeep[i]);
            end
        end
    end

    // Register the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_miss  <= 1'b0;
            rs_fault <= 1'b0;
            rs_paddr <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_miss  <= lk_valid && !sel_found;
            rs_fault <= lk_valid && sel_found && lk_write && !sel_wr;
            rs_hit   <= lk_valid && sel_found && !(lk_write && !sel_wr);
            rs_paddr <= (lk_valid && sel_found && !(lk_write && !sel_wr)) ? sel_pa : '0;
        end
    end

    // Valid bits and replacement pointer: purge first, refill overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            if (purge_valid) begin
                if (purge_all) vld_q <= '0;
                else           vld_q <= vld_q & ~pg_hit;
            end
            if (fill_valid) begin
                vld_q[vic_idx] <= 1'b1;
                if (vic_use_ptr)
                    ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // Slot payload, written only by refill.
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            va_q[vic_idx]  <= fill_vaddr;
            pa_q[vic_idx]  <= fill_paddr;
            sz_q[vic_idx]  <= pg_size_e'(fill_size);
            pid_q[vic_idx] <= fill_pid;
            wr_q[vic_idx]  <= fill_writable;
        end
    end
endmodule

// File: rtl/tagged_tlb_chk.sv
// tagged_tlb_chk: protocol and result properties of tagged_tlb, bound in.
// Assumes: the valid vector is brought out from the design for R11.
module tagged_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_write,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic               rs_miss,
    input logic               rs_fault,
    input logic [PA_W-1:0]    rs_paddr,
    input logic               purge_valid,
    input logic               purge_all,
    input logic               fill_valid,
    input logic [ENTRIES-1:0] vld_q
);
    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    // R13
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault}));
    // R13
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> ({rs_hit, rs_miss, rs_fault} == 3'b000));
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> (rs_paddr[11:0] == $past(lk_vaddr[11:0])));
    // R6
    fault_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> ($past(lk_write) && rs_paddr == '0));
    // R11
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_valid && purge_all && !fill_valid) |=> (vld_q == '0));
endmodule

bind tagged_tlb tagged_tlb_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_miss(rs_miss), .rs_fault(rs_fault), .rs_paddr(rs_paddr),
    .purge_valid(purge_valid), .purge_all(purge_all),
    .fill_valid(fill_valid), .vld_q(vld_q));

// File: tb/tagged_tlb_test.sv
// tagged_tlb_test: scoreboard bench. Lookup calls queue the expected outcome;
// a monitor pops and compares each registered result.
module tagged_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        rs_valid, rs_hit, rs_miss, rs_fault;
    logic [31:0] rs_paddr;
    logic        fill_valid = 1'b0, fill_writable = 1'b0;
    logic [31:0] fill_vaddr = '0, fill_paddr = '0;
    logic [1:0]  fill_size = '0;
    logic [7:0]  fill_pid = '0;
    logic        purge_valid = 1'b0, purge_all = 1'b0;
    logic [31:0] purge_vaddr = '0;
    logic [7:0]  purge_pid = '0;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int          kind;   // 0 miss, 1 hit, 2 fault
        logic [31:0] pa;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    tagged_tlb uut (.*);

    function automatic void check(bit ok, string req, string what,
                                  logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endfunction

    // Monitor: compare each result against the oldest queued expectation (R2, R13).
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            int k;
            k = ({rs_fault, rs_hit, rs_miss} == 3'b001) ? 0 :
                ({rs_fault, rs_hit, rs_miss} == 3'b010) ? 1 :
                ({rs_fault, rs_hit, rs_miss} == 3'b100) ? 2 : 3;
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 32'(k), 32'hffff_ffff);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(k == e.kind, e.req, "outcome", 32'(k), 32'(e.kind));
                if (e.kind == 1 && k == 1)
                    check(rs_paddr == e.pa, e.req, "paddr", rs_paddr, e.pa);
            end
        end
    end

    task automatic set_lk(logic [31:0] va, bit wr, logic [7:0] pid,
                          int kind, logic [31:0] pa, string req);
        exp_t e;
        e.kind = kind; e.pa = pa; e.req = req;
        sb.push_back(e);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_pid = pid;
    endtask

    task automatic set_fill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz,
                            logic [7:0] pid, bit wr);
        fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa;
        fill_size = sz; fill_pid = pid; fill_writable = wr;
    endtask

    task automatic set_purge(logic [31:0] va, logic [7:0] pid, bit all);
        purge_valid = 1'b1; purge_vaddr = va; purge_pid = pid; purge_all = all;
    endtask

    task automatic step();
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0; fill_valid = 1'b0;
        purge_valid = 1'b0; purge_all = 1'b0;
    endtask

    task automatic lk(logic [31:0] va, bit wr, logic [7:0] pid,
                      int kind, logic [31:0] pa, string req);
        set_lk(va, wr, pid, kind, pa, req);
        step();
    endtask

    task automatic fill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz,
                        logic [7:0] pid, bit wr);
        set_fill(va, pa, sz, pid, wr);
        step();
    endtask

    localparam logic [7:0] P = 8'd5;
    function automatic logic [31:0] va4k(int k);
        return 32'h0010_0000 + 32'(k) * 32'h1000;
    endfunction
    function automatic logic [31:0] pa4k(int k);
        return 32'h0A00_0000 + 32'(k) * 32'h1000;
    endfunction
    function automatic logic [31:0] vnew(int k);
        return 32'h0050_0000 + 32'(k) * 32'h1_0000;
    endfunction
    function automatic logic [31:0] pnew(int k);
        return 32'h0C00_0000 + 32'(k) * 32'h1_0000;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(!rs_valid && !rs_hit && !rs_miss && !rs_fault, "R1", "reset outputs",
              {28'd0, rs_valid, rs_hit, rs_miss, rs_fault}, 32'd0);
        lk(32'h4000_0000, 1'b0, P, 0, '0, "R1");

        // R12: lookup concurrent with the refill of its page still misses
        set_lk(32'h4000_0123, 1'b0, P, 0, '0, "R12");
        set_fill(32'h4000_0000, 32'h8000_0000, 2'd2, P, 1'b1);   // slot 0, 1 GB
        step();
        fill(32'h0020_0000, 32'h0660_0000, 2'd1, P, 1'b0);       // slot 1, 2 MB, read-only
        for (int k = 2; k < 8; k++) fill(va4k(k), pa4k(k), 2'd0, P, 1'b1);

        // R4: large pages pass wide offsets
        lk(32'h4123_4567, 1'b0, P, 1, 32'h8123_4567, "R4");
        lk(32'h7FFF_FFFF, 1'b1, P, 1, 32'hBFFF_FFFF, "R4");
        lk(32'h0023_4567, 1'b0, P, 1, 32'h0663_4567, "R4");
        // R6: write to read-only slot faults, read hits
        lk(32'h0023_4567, 1'b1, P, 2, '0, "R6");
        lk(32'h003F_FFFF, 1'b0, P, 1, 32'h067F_FFFF, "R6");
        // R3: 4 KB translation
        lk(va4k(2) | 32'hABC, 1'b0, P, 1, pa4k(2) | 32'hABC, "R3");
        lk(va4k(7) | 32'hFFF, 1'b1, P, 1, pa4k(7) | 32'hFFF, "R3");
        // R5: other process misses
        lk(va4k(2), 1'b0, 8'd6, 0, '0, "R5");
        lk(32'h4123_4567, 1'b0, 8'd0, 0, '0, "R5");

        // R10: purge for another process has no effect
        set_purge(va4k(3), 8'd6, 1'b0); step();
        lk(va4k(3), 1'b0, P, 1, pa4k(3), "R10");
        set_purge(va4k(3) | 32'h55, P, 1'b0); step();
        lk(va4k(3), 1'b0, P, 0, '0, "R10");
        lk(va4k(2), 1'b0, P, 1, pa4k(2), "R10");
        // R12: lookup concurrent with purge sees the old table
        set_lk(va4k(4), 1'b0, P, 1, pa4k(4), "R12");
        set_purge(va4k(4), P, 1'b0);
        step();
        lk(va4k(4), 1'b0, P, 0, '0, "R12");

        // R7: new pages go into the freed slots 3 and 4
        fill(vnew(0), pnew(0), 2'd0, P, 1'b1);
        fill(vnew(1), pnew(1), 2'd0, P, 1'b1);
        lk(32'h4000_0010, 1'b0, P, 1, 32'h8000_0010, "R7");
        lk(32'h0020_0000, 1'b0, P, 1, 32'h0660_0000, "R7");
        lk(va4k(5), 1'b0, P, 1, pa4k(5), "R7");
        lk(va4k(7), 1'b0, P, 1, pa4k(7), "R7");
        lk(vnew(0), 1'b0, P, 1, pnew(0), "R7");
        lk(vnew(1), 1'b0, P, 1, pnew(1), "R7");

        // R8: full table, pointer replaces slot 0 then slot 1
        fill(vnew(2), pnew(2), 2'd0, P, 1'b1);
        lk(32'h4123_4567, 1'b0, P, 0, '0, "R8");
        lk(32'h0023_4567, 1'b0, P, 1, 32'h0663_4567, "R8");
        fill(vnew(3), pnew(3), 2'd0, P, 1'b1);
        lk(32'h0023_4567, 1'b0, P, 0, '0, "R8");
        lk(va4k(2), 1'b0, P, 1, pa4k(2), "R8");
        lk(vnew(2), 1'b0, P, 1, pnew(2), "R8");

        // R9: refill of an installed page rewrites it in place
        fill(va4k(5), 32'h0B00_0000, 2'd0, P, 1'b1);
        lk(va4k(5) | 32'h321, 1'b0, P, 1, 32'h0B00_0321, "R9");
        lk(va4k(2), 1'b0, P, 1, pa4k(2), "R9");
        lk(vnew(3), 1'b0, P, 1, pnew(3), "R9");
        // R8/R9: pointer did not move, next replacement takes slot 2
        fill(vnew(4), pnew(4), 2'd0, P, 1'b1);
        lk(va4k(2), 1'b0, P, 0, '0, "R9");
        lk(va4k(6), 1'b0, P, 1, pa4k(6), "R8");
        lk(vnew(4), 1'b0, P, 1, pnew(4), "R8");

        // R11: purge everything
        set_purge('0, '0, 1'b1); step();
        lk(va4k(6), 1'b0, P, 0, '0, "R11");
        lk(vnew(0), 1'b0, P, 0, '0, "R11");
        lk(va4k(5), 1'b0, P, 0, '0, "R11");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "results outstanding", 32'(sb.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule